// File: doc/BRIEF.md
# Non-Prefetchable Single-Phase PCI Target Path

This block is the single-beat target data path of a bridge from a PCI bus to a memory-mapped fabric. It watches a simplified PCI target interface, decodes each memory transaction against a set of base address windows, and serves the transactions that fall on this path with exactly one data phase. Writes are forwarded as one master-port write and completed within the same bus transaction. Reads are handled as delayed transactions. The first attempt is terminated with a retry while the read is issued on the master port in the background. A later attempt with the same address and command collects the returned word.

The bus side is handled by one state machine. Its states are IDLE (wait for an address phase on an idle bus), DECODE (the window check runs on the latched address and command), WR_WAIT (claimed write, waiting for IRDY#), WR_MST (write word on the master port), XFER (TRDY# and STOP# together, the single data phase), FINISH (disconnect held after the data phase until FRAME# rises) and RETRY (STOP# without TRDY# until FRAME# rises).

Transitions:
- IDLE→DECODE on an address phase.
- DECODE→IDLE when the transaction is not claimed.
- DECODE→WR_WAIT for a write that may proceed.
- DECODE→RETRY for a blocked write, a first read, a mismatching read, or a read whose data is not back.
- DECODE→XFER for a matching read whose data is held.
- WR_WAIT→WR_MST on IRDY#.
- WR_MST→XFER on write accept.
- XFER→IDLE when the data phase completes with FRAME# already high.
- XFER→FINISH when the data phase completes with FRAME# still low.
- FINISH→IDLE and RETRY→IDLE once FRAME# is high.

A separate keeper holds the one pending read (address, command, data, discard timer) and owns the master port.

Top module: `npf_target_path`

## Requirements
- R1: A transaction is claimed only when all of the following hold. Its command is a memory read (0110, 1100, 1110) or a memory write (0111, 1111). Its address falls in a window whose prefetchable flag is clear, or in any window while `single_only` is 1. The default windows are 4 KiB at 0x1000_0000 (non-prefetchable) and 4 KiB at 0x2000_0000 (prefetchable). Any other transaction leaves DEVSEL#, TRDY# and STOP# high.
- R2: For a claimed transaction, DEVSEL# stays high in the clock that follows the address-phase edge. It goes low at the second rising edge after that edge.
- R3: A claimed write that is not blocked produces exactly one master write carrying the bus address and the data word present with IRDY#. TRDY# is given only after the master port has accepted that write.
- R4: TRDY# is low only while STOP# and DEVSEL# are also low. Each transaction moves at most one data word, even when FRAME# stays low.
- R5: A read attempt with nothing pending is retried (STOP# low, TRDY# high). The read is then issued once on the master port with the bus address.
- R6: A repeated read whose address and command match the pending one, arriving after its data has returned, completes with that data on `ad_out`. The pending state is then cleared, so the next identical read starts afresh.
- R7: A matching repeat that arrives before the data has returned is retried again, and no second master read is issued.
- R8: A read with a different address or command, arriving while a read is pending, is retried. The stored request is left unchanged and still completes later.
- R9: A write arriving while the pending read has not yet returned data is retried with no master write. Once the data is back, writes are accepted.
- R10: Held read data that is not collected within 2^15 clocks of its return is dropped. The next identical read is then treated as a new request.
- R11: While `m_waitreq` is high, the master port keeps its command and `m_addr` unchanged, and never asserts read and write together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_only | input | 1 | Route every window hit to this path |
| frame_n | input | 1 | Initiator FRAME#, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cmd_in | input | 4 | Bus command, sampled in the address phase |
| ad_in | input | 32 | Address in address phase, write data in data phase |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop (retry or disconnect), active low |
| ad_out | output | 32 | Read data during a read data phase, zero otherwise |
| m_addr | output | 32 | Master port address |
| m_read | output | 1 | Master read request |
| m_write | output | 1 | Master write request |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Master read data |
| m_waitreq | input | 1 | Master stall |
| m_rdvalid | input | 1 | Master read data valid |

## Verification
The embedded assertions check every cycle that TRDY# never appears without STOP# and DEVSEL#, that DEVSEL# only falls two edges after an address phase, and that read data is driven only while a returned word is held. They also check that a write never reaches the master port while a read is in flight, that a new request never overwrites a pending one, and that master commands hold steady under stall. Only the bench scenarios show the delayed-read sequence end to end. That covers retry then completion with the right word, repeats and mismatches that leave the stored request intact, write ordering against an outstanding read, and the discard after 2^15 idle clocks, all judged against a behavioural model of the pending request.

// File: rtl/npf_pkg.sv
package npf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WR_WAIT,
        ST_WR_MST,
        ST_XFER,
        ST_FINISH,
        ST_RETRY
    } tgt_state_e;

    localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
    localparam logic [3:0] CMD_MEM_WR      = 4'b0111;
    localparam logic [3:0] CMD_MEM_WR_INV  = 4'b1111;

    function automatic logic cmd_is_read(input logic [3:0] c);
        return (c == CMD_MEM_RD) || (c == CMD_MEM_RD_MULT) || (c == CMD_MEM_RD_LINE);
    endfunction

    function automatic logic cmd_is_write(input logic [3:0] c);
        return (c == CMD_MEM_WR) || (c == CMD_MEM_WR_INV);
    endfunction

endpackage

// File: rtl/npf_bar_match.sv
module npf_bar_match #(
    parameter int AD_W          = 32,
    parameter int NUM_BARS      = 2,
    parameter int APERTURE_LOG2 = 12,
    parameter logic [NUM_BARS-1:0][AD_W-1:0] BAR_BASE = {32'h2000_0000, 32'h1000_0000},
    parameter logic [NUM_BARS-1:0]           BAR_PREF = 2'b10
) (
    input  logic [AD_W-1:0] addr,
    input  logic            single_only,
    output logic            hit
);
    localparam int TAG_LO = APERTURE_LOG2;

    logic [NUM_BARS-1:0] win_hit;

    generate
        for (genvar b = 0; b < NUM_BARS; b++) begin : g_win
            // a prefetchable window belongs here only in single-beat-only mode
            assign win_hit[b] = (addr[AD_W-1:TAG_LO] == BAR_BASE[b][AD_W-1:TAG_LO])
                                && (!BAR_PREF[b] || single_only);
        end
    endgenerate

    assign hit = |win_hit;

endmodule

// File: rtl/npf_dr_keeper.sv
module npf_dr_keeper #(
    parameter int AD_W         = 32,
    parameter int DISCARD_LOG2 = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    // from bus state machine
    input  logic            new_req,
    input  logic [AD_W-1:0] txn_addr,
    input  logic [3:0]      txn_cmd,
    input  logic            rd_taken,
    input  logic            wr_req,
    input  logic [AD_W-1:0] wr_data,
    // to bus state machine
    output logic            pend,
    output logic            rd_ready,
    output logic            rd_busy,
    output logic            match,
    output logic [AD_W-1:0] rd_data,
    output logic            wr_ack,
    // master port
    output logic [AD_W-1:0] m_addr,
    output logic            m_read,
    output logic            m_write,
    output logic [AD_W-1:0] m_wdata,
    input  logic [AD_W-1:0] m_rdata,
    input  logic            m_waitreq,
    input  logic            m_rdvalid
);
    logic                    pend_q, issued_q, valid_q;
    logic [AD_W-1:0]         addr_q, data_q;
    logic [3:0]              cmd_q;
    logic [DISCARD_LOG2-1:0] tmr_q;
    logic                    expire;

    assign expire   = valid_q && (tmr_q == '1);
    assign pend     = pend_q;
    assign rd_ready = valid_q;
    assign rd_busy  = pend_q && !valid_q;
    assign match    = pend_q && (addr_q == txn_addr) && (cmd_q == txn_cmd);
    assign rd_data  = data_q;

    assign m_read   = pend_q && !issued_q;
    assign m_write  = wr_req;
    assign m_addr   = m_write ? txn_addr : addr_q;
    assign m_wdata  = wr_data;
    assign wr_ack   = m_write && !m_waitreq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            issued_q <= 1'b0;
            valid_q  <= 1'b0;
            addr_q   <= '0;
            cmd_q    <= '0;
            data_q   <= '0;
            tmr_q    <= '0;
        end else if (new_req) begin
            pend_q   <= 1'b1;
            issued_q <= 1'b0;
            valid_q  <= 1'b0;
            addr_q   <= txn_addr;
            cmd_q    <= txn_cmd;
            tmr_q    <= '0;
        end else if (rd_taken || expire) begin
            pend_q   <= 1'b0;
            issued_q <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            if (m_read && !m_waitreq)
                issued_q <= 1'b1;
            if (issued_q && !valid_q && m_rdvalid) begin
                valid_q <= 1'b1;
                data_q  <= m_rdata;
                tmr_q   <= '0;
            end else if (valid_q) begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    // R9
    write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_write |-> (!pend_q || valid_q));

    // R8
    no_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_req |-> !pend_q);

    // R11
    mst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_read || m_write) && m_waitreq |=>
            (m_read == $past(m_read)) && (m_write == $past(m_write)) && (m_addr == $past(m_addr)));

    // R11
    single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_read && m_write));

endmodule

// File: rtl/npf_target_path.sv
module npf_target_path
    import npf_pkg::*;
#(
    parameter int AD_W          = 32,
    parameter int NUM_BARS      = 2,
    parameter int APERTURE_LOG2 = 12,
    parameter logic [NUM_BARS-1:0][AD_W-1:0] BAR_BASE = {32'h2000_0000, 32'h1000_0000},
    parameter logic [NUM_BARS-1:0]           BAR_PREF = 2'b10,
    parameter int DISCARD_LOG2  = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            single_only,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic [3:0]      cmd_in,
    input  logic [AD_W-1:0] ad_in,
    output logic            devsel_n,
    output logic            trdy_n,
    output logic            stop_n,
    output logic [AD_W-1:0] ad_out,
    output logic [AD_W-1:0] m_addr,
    output logic            m_read,
    output logic            m_write,
    output logic [AD_W-1:0] m_wdata,
    input  logic [AD_W-1:0] m_rdata,
    input  logic            m_waitreq,
    input  logic            m_rdvalid
);
    tgt_state_e      state_q, state_d;
    logic [AD_W-1:0] txn_addr_q, wdata_q;
    logic [3:0]      txn_cmd_q;
    logic            bus_idle_q;

    logic            hit, txn_rd, txn_wr;
    logic            pend, rd_ready, rd_busy, match, wr_ack;
    logic [AD_W-1:0] rd_data;
    logic            new_req, rd_taken, wr_req;

    assign txn_rd = cmd_is_read(txn_cmd_q);
    assign txn_wr = cmd_is_write(txn_cmd_q);

    npf_bar_match #(
        .AD_W(AD_W), .NUM_BARS(NUM_BARS), .APERTURE_LOG2(APERTURE_LOG2),
        .BAR_BASE(BAR_BASE), .BAR_PREF(BAR_PREF)
    ) u_bar (
        .addr(txn_addr_q), .single_only(single_only), .hit(hit)
    );

    assign new_req  = (state_q == ST_DECODE) && hit && txn_rd && !pend;
    assign rd_taken = (state_q == ST_XFER) && txn_rd && !irdy_n;
    assign wr_req   = (state_q == ST_WR_MST);

    npf_dr_keeper #(.AD_W(AD_W), .DISCARD_LOG2(DISCARD_LOG2)) u_keep (
        .clk(clk), .rst_n(rst_n),
        .new_req(new_req), .txn_addr(txn_addr_q), .txn_cmd(txn_cmd_q),
        .rd_taken(rd_taken), .wr_req(wr_req), .wr_data(wdata_q),
        .pend(pend), .rd_ready(rd_ready), .rd_busy(rd_busy), .match(match),
        .rd_data(rd_data), .wr_ack(wr_ack),
        .m_addr(m_addr), .m_read(m_read), .m_write(m_write), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_waitreq(m_waitreq), .m_rdvalid(m_rdvalid)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (!frame_n && bus_idle_q) state_d = ST_DECODE;
            ST_DECODE: begin
                if (!hit || !(txn_rd || txn_wr))
                    state_d = ST_IDLE;
                else if (txn_wr)
                    state_d = rd_busy ? ST_RETRY : ST_WR_WAIT;
                else
                    state_d = (match && rd_ready) ? ST_XFER : ST_RETRY;
            end
            ST_WR_WAIT: if (!irdy_n) state_d = ST_WR_MST;
            ST_WR_MST:  if (wr_ack) state_d = ST_XFER;
            ST_XFER:    if (!irdy_n) state_d = frame_n ? ST_IDLE : ST_FINISH;
            ST_FINISH:  if (frame_n) state_d = ST_IDLE;
            ST_RETRY:   if (frame_n) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state and transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            txn_addr_q <= '0;
            txn_cmd_q  <= '0;
            wdata_q    <= '0;
            bus_idle_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            bus_idle_q <= frame_n && irdy_n;
            if ((state_q == ST_IDLE) && !frame_n && bus_idle_q) begin
                txn_addr_q <= ad_in;
                txn_cmd_q  <= cmd_in;
            end
            if ((state_q == ST_WR_WAIT) && !irdy_n)
                wdata_q <= ad_in;
        end
    end

    // bus outputs, decoded from the state
    always_comb begin
        devsel_n = 1'b1;
        trdy_n   = 1'b1;
        stop_n   = 1'b1;
        ad_out   = '0;
        unique case (state_q)
            ST_WR_WAIT, ST_WR_MST: devsel_n = 1'b0;
            ST_XFER: begin
                devsel_n = 1'b0;
                trdy_n   = 1'b0;
                stop_n   = 1'b0;
                if (txn_rd) ad_out = rd_data;
            end
            ST_FINISH, ST_RETRY: begin
                devsel_n = 1'b0;
                stop_n   = 1'b0;
            end
            default: ;
        endcase
    end

    // R4
    disconnect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> (!stop_n && !devsel_n));

    // R2
    devsel_medium_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> $past(!frame_n && bus_idle_q, 2));

    // R6
    read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && txn_rd) |-> rd_ready);

    // R3
    write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(trdy_n) && txn_wr) |-> $past(wr_ack));

endmodule

// File: tb/test_npf_target_path.sv
module test_npf_target_path;

    localparam logic [31:0] RD_MASK = 32'h5A5A_0000;
    localparam int          HOLD    = 32768;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        single_only = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cmd_in = 4'h0;
    logic [31:0] ad_in = '0;
    logic        devsel_n, trdy_n, stop_n;
    logic [31:0] ad_out, m_addr, m_wdata;
    logic        m_read, m_write;
    logic [31:0] m_rdata = '0;
    logic        m_waitreq;
    logic        m_rdvalid = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    npf_target_path i_npf_target_path (
        .clk(clk), .rst_n(rst_n), .single_only(single_only),
        .frame_n(frame_n), .irdy_n(irdy_n), .cmd_in(cmd_in), .ad_in(ad_in),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ad_out(ad_out),
        .m_addr(m_addr), .m_read(m_read), .m_write(m_write), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_waitreq(m_waitreq), .m_rdvalid(m_rdvalid)
    );

    // ---------------- memory-side responder and log ----------------
    int          wait_n = 0;
    int          rd_lat = 3;
    int          busy_cnt = 0;
    int          cyc = 0;
    bit          rv_act = 0;
    int          rv_cnt = 0;
    logic [31:0] rv_addr = '0;
    int          rv_count = 0;
    int          rv_last_cyc = 0;
    bit          log_w[$];
    logic [31:0] log_a[$];
    logic [31:0] log_d[$];

    assign m_waitreq = (m_read || m_write) && (busy_cnt < wait_n);

    always @(posedge clk) begin
        cyc      <= cyc + 1;
        busy_cnt <= ((m_read || m_write) && m_waitreq) ? busy_cnt + 1 : 0;
        m_rdvalid <= 1'b0;
        if (rv_act) begin
            if (rv_cnt <= 1) begin
                m_rdvalid   <= 1'b1;
                m_rdata     <= rv_addr ^ RD_MASK;
                rv_act      <= 1'b0;
                rv_count    <= rv_count + 1;
                rv_last_cyc <= cyc;
            end else begin
                rv_cnt <= rv_cnt - 1;
            end
        end
        if (m_read && !m_waitreq) begin
            rv_act  <= 1'b1;
            rv_cnt  <= rd_lat;
            rv_addr <= m_addr;
        end
        if ((m_read || m_write) && !m_waitreq) begin
            log_w.push_back(m_write);
            log_a.push_back(m_addr);
            log_d.push_back(m_wdata);
        end
    end

    // ---------------- reporting ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- per-clock protocol comparison ----------------
    bit          prev_stall = 0;
    bit          prev_rd = 0, prev_wr = 0;
    logic [31:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            // R4: data phase only with disconnect and select
            check(trdy_n || (!stop_n && !devsel_n), "R4", "trdy without stop/devsel",
                  {29'd0, trdy_n, stop_n, devsel_n}, 32'd0);
            // R11: stall holds master command
            check(!(m_read && m_write), "R11", "read and write together",
                  {30'd0, m_read, m_write}, 32'd0);
            if (prev_stall)
                check((m_read == prev_rd) && (m_write == prev_wr) && (m_addr == prev_addr),
                      "R11", "master changed under stall", m_addr, prev_addr);
            prev_stall = (m_read || m_write) && m_waitreq;
            prev_rd    = m_read;
            prev_wr    = m_write;
            prev_addr  = m_addr;
        end
    end

    // ---------------- behavioural model of the pending read ----------------
    bit          mdl_pend = 0;
    logic [31:0] mdl_a = '0;
    logic [3:0]  mdl_c = '0;
    int          mdl_base = 0;
    int          exp_len = 0;

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // kind: 0 no claim, 1 retry, 2 data
    task automatic pci_txn(input logic [3:0] c, input logic [31:0] a, input logic [31:0] wd,
                           input bit more, input string req);
        int          expk;
        int          gotk;
        logic [31:0] gotd;
        bit          is_rd, is_wr, claimed, ready, fresh;
        is_rd   = (c == 4'h6) || (c == 4'hC) || (c == 4'hE);
        is_wr   = (c == 4'h7) || (c == 4'hF);
        claimed = (is_rd || is_wr) &&
                  ((a[31:12] == 20'h10000) || ((a[31:12] == 20'h20000) && single_only));
        ready   = mdl_pend && (rv_count > mdl_base);
        if (ready && (cyc - rv_last_cyc) > HOLD + 1) begin
            mdl_pend = 0;
            ready    = 0;
        end
        fresh = 0;
        if (!claimed)      expk = 0;
        else if (is_wr)    expk = (mdl_pend && !ready) ? 1 : 2;
        else if (!mdl_pend) begin
            expk = 1; fresh = 1; mdl_pend = 1; mdl_a = a; mdl_c = c; mdl_base = rv_count;
        end else if (mdl_a == a && mdl_c == c && ready) expk = 2;
        else expk = 1;

        @(negedge clk);
        frame_n = 1'b0; ad_in = a; cmd_in = c;
        @(negedge clk);
        check(devsel_n == 1'b1, "R2", "devsel in decode clock", {31'd0, devsel_n}, 32'd1);
        irdy_n = 1'b0; frame_n = more ? 1'b0 : 1'b1; ad_in = wd; cmd_in = 4'h0;
        gotk = 0; gotd = '0;
        for (int k = 0; k < 12 && gotk == 0; k++) begin
            @(negedge clk);
            if (k == 0)
                check(devsel_n == (expk == 0), (expk == 0) ? "R1" : "R2",
                      "devsel at second edge", {31'd0, devsel_n}, {31'd0, expk == 0});
            if (!stop_n || !trdy_n) begin
                gotk = trdy_n ? 1 : 2;
                gotd = ad_out;
            end
        end
        if (gotk == 0) begin
            frame_n = 1'b1;
            @(negedge clk);
            irdy_n = 1'b1;
        end else begin
            if (!frame_n) begin
                @(negedge clk);
                check(trdy_n == 1'b1, "R4", "second data phase", {31'd0, trdy_n}, 32'd1);
                frame_n = 1'b1;
            end
            @(negedge clk);
            check(trdy_n == 1'b1, "R4", "trdy after termination", {31'd0, trdy_n}, 32'd1);
            irdy_n = 1'b1;
        end
        idle(3);

        check(gotk == expk, req, "termination kind", gotk, expk);
        if (expk == 2 && is_rd) begin
            check(gotd == (a ^ RD_MASK), req, "read data", gotd, a ^ RD_MASK);
            mdl_pend = 0;
        end
        if (fresh || (expk == 2 && is_wr)) exp_len++;
        check(log_w.size() == exp_len, req, "master op count", log_w.size(), exp_len);
        if (log_w.size() == exp_len && exp_len > 0) begin
            if (fresh)
                check(!log_w[exp_len-1] && log_a[exp_len-1] == a, "R5", "issued read",
                      log_a[exp_len-1], a);
            if (expk == 2 && is_wr)
                check(log_w[exp_len-1] && log_a[exp_len-1] == a && log_d[exp_len-1] == wd,
                      "R3", "forwarded write", log_d[exp_len-1], wd);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        idle(4);
        // reset state (R1: nothing claimed, R11: master idle)
        check(devsel_n && trdy_n && stop_n, "R1", "reset bus outputs",
              {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
        check(!m_read && !m_write, "R11", "reset master idle", {30'd0, m_read, m_write}, 32'd0);
        rst_n = 1'b1;
        idle(3);

        // R3 plain write, then R4 write with FRAME# held low and stalls
        pci_txn(4'h7, 32'h1000_0010, 32'hCAFE_0001, 0, "R3");
        wait_n = 2;
        pci_txn(4'hF, 32'h1000_0020, 32'hCAFE_0002, 1, "R4");

        // R5 first read retried, R6 repeat completes, then starts afresh
        rd_lat = 3;
        pci_txn(4'h6, 32'h1000_0100, 32'h0, 0, "R5");
        idle(10);
        pci_txn(4'h6, 32'h1000_0100, 32'h0, 1, "R6");
        pci_txn(4'h6, 32'h1000_0100, 32'h0, 0, "R6");
        idle(10);
        pci_txn(4'h6, 32'h1000_0100, 32'h0, 0, "R6");

        // R7 repeat before data returns
        wait_n = 0;
        rd_lat = 40;
        pci_txn(4'hC, 32'h1000_0200, 32'h0, 0, "R5");
        pci_txn(4'hC, 32'h1000_0200, 32'h0, 0, "R7");

        // R8 mismatching address and command
        pci_txn(4'hC, 32'h1000_0300, 32'h0, 0, "R8");
        pci_txn(4'h6, 32'h1000_0200, 32'h0, 0, "R8");

        // R9 write while read in flight, then after data returned
        pci_txn(4'h7, 32'h1000_0040, 32'hBEEF_0003, 0, "R9");
        idle(50);
        pci_txn(4'h7, 32'h1000_0040, 32'hBEEF_0004, 0, "R9");
        pci_txn(4'hC, 32'h1000_0200, 32'h0, 0, "R8");

        // R1 decode: prefetchable window, I/O command, miss
        rd_lat = 3;
        pci_txn(4'h6, 32'h2000_0010, 32'h0, 0, "R1");
        pci_txn(4'h2, 32'h1000_0010, 32'h0, 0, "R1");
        pci_txn(4'h6, 32'h3000_0010, 32'h0, 0, "R1");
        pci_txn(4'h7, 32'h2000_0010, 32'h1111_2222, 0, "R1");
        single_only = 1'b1;
        pci_txn(4'hE, 32'h2000_0080, 32'h0, 0, "R1");
        idle(10);
        pci_txn(4'hE, 32'h2000_0080, 32'h0, 0, "R1");
        pci_txn(4'h7, 32'h2000_0090, 32'h3333_4444, 0, "R1");
        single_only = 1'b0;

        // R10 discard of uncollected data
        pci_txn(4'h6, 32'h1000_0500, 32'h0, 0, "R5");
        idle(HOLD + 40);
        pci_txn(4'h6, 32'h1000_0500, 32'h0, 0, "R10");
        idle(10);
        pci_txn(4'h6, 32'h1000_0500, 32'h0, 0, "R10");

        idle(5);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule